// File: doc/BRIEF.md
# Nibble Ones-Run Decoder

This block turns a packed stream of 4-bit run codes back into a serial bit stream, such as a configuration image whose data runs are made mostly of ones. Each code either stands for a single zero bit followed by a short run of ones, or for a fixed long run of ones with no zero. Chaining long-run codes therefore rebuilds runs of any length. The output bits carry no byte alignment.

Bytes arrive over a valid/ready input, and each byte holds two codes. The expanded bits leave one per cycle over a valid/ready output. The decoder can stall on output back-pressure at any bit. One code value is reserved. If it arrives, the decoder skips it without emitting anything and latches an error flag that stays set until reset.

Top module: `nibble_run_expander`

## Requirements
- R1: After a synchronous reset, `in_ready` is 1, `out_valid` is 0 and `err` is 0.
- R2: A code value K in the range 0 to 13 produces one 0 bit followed by K 1 bits. Code 0 therefore produces a single 0 bit.
- R3: Code value 14 produces exactly fourteen 1 bits and no 0 bit. Consecutive 14 codes join into a single longer run of ones.
- R4: Within an input byte, the code in bits [7:4] is fully expanded before the code in bits [3:0].
- R5: Code value 15 produces no output bit. It sets `err`, which stays at 1 until the next reset, whatever data follows.
- R6: After a byte is accepted, `in_ready` stays low until both of its codes have been fully expanded.
- R7: While `out_valid` is 1 and `out_ready` is 0, `out_valid` stays 1, `out_bit` holds its value and no bit is lost or repeated.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input byte is valid |
| in_ready | output | 1 | Decoder can take a byte |
| in_byte | input | 8 | Two codes: first code in [7:4], second in [3:0] |
| out_valid | output | 1 | `out_bit` holds a decoded bit |
| out_ready | input | 1 | Consumer takes the bit this cycle |
| out_bit | output | 1 | Decoded serial bit |
| err | output | 1 | Sticky flag set by reserved code 15 |

## Verification
The hardest case to reach from the ports is a stall that lands exactly on the first bit of a new code: the zero of a short code, or the first one of a long code. At that point the code's value is still being decoded straight from the held byte. The bench drives `out_ready` from a pseudo-random pattern while feeding bytes that mix code 0, code 13, code 14 and the reserved code in both nibble positions. Over these runs, stalls fall on every phase of the decoder, including directly after a skipped reserved code.

// File: rtl/nibble_run_expander.sv
module nibble_run_expander #(
  parameter int CODE_W = 4
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  in_valid,
  output logic                  in_ready,
  input  logic [2*CODE_W-1:0]   in_byte,
  output logic                  out_valid,
  input  logic                  out_ready,
  output logic                  out_bit,
  output logic                  err
);
  localparam int BYTE_W = 2 * CODE_W;
  localparam int RSVD   = (1 << CODE_W) - 1;
  localparam int LONG   = (1 << CODE_W) - 2;

  logic              hold, sel, phase;
  logic [CODE_W-1:0] cnt;
  logic [BYTE_W-1:0] byte_q;

  logic [CODE_W-1:0] nib;
  logic is_rsvd, is_long, fire, skip, nib_done;

  assign nib      = sel ? byte_q[CODE_W-1:0] : byte_q[BYTE_W-1:CODE_W];
  assign is_rsvd  = (nib == CODE_W'(RSVD));
  assign is_long  = (nib == CODE_W'(LONG));
  assign in_ready = !hold;
  assign out_valid = hold && (phase || !is_rsvd);
  assign out_bit  = phase || is_long;
  assign fire     = out_valid && out_ready;
  assign skip     = hold && !phase && is_rsvd;
  assign nib_done = skip || (fire && (phase ? (cnt == CODE_W'(1)) : (nib == '0)));

  always_ff @(posedge clk) begin
    if (rst) begin
      hold   <= 1'b0;
      sel    <= 1'b0;
      phase  <= 1'b0;
      cnt    <= '0;
      byte_q <= '0;
      err    <= 1'b0;
    end else begin
      if (in_valid && in_ready) begin
        byte_q <= in_byte;
        hold   <= 1'b1;
        sel    <= 1'b0;
        phase  <= 1'b0;
      end else if (nib_done) begin
        phase <= 1'b0;
        cnt   <= '0;
        if (sel) begin
          hold <= 1'b0;
          sel  <= 1'b0;
        end else begin
          sel <= 1'b1;
        end
      end else if (fire) begin
        if (phase) begin
          cnt <= cnt - CODE_W'(1);
        end else begin
          phase <= 1'b1;
          cnt   <= is_long ? CODE_W'(LONG - 1) : nib;
        end
      end
      if (skip) err <= 1'b1;
    end
  end

  // R7
  stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_bit));

  // R6
  accept_block_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid && in_ready |=> !in_ready);

  // R5
  err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    err |=> err);

  // R3
  run_bound_chk: assert property (@(posedge clk) disable iff (rst)
    cnt <= CODE_W'(LONG - 1));

  // R2
  zero_then_one_chk: assert property (@(posedge clk) disable iff (rst)
    fire && !out_bit && nib != '0 |=> out_valid && out_bit);
endmodule

// File: tb/nibble_run_expander_tb_top.sv
module nibble_run_expander_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic [7:0] in_byte = 8'h00;
  logic out_ready = 1'b1;
  logic in_ready, out_valid, out_bit, err;

  int n_chk = 0;
  int n_bad = 0;
  bit exp_q[$];
  bit stall_en = 1'b0;
  bit prev_stall = 1'b0;
  bit prev_bit = 1'b0;
  logic [7:0] lfsr = 8'hA5;

  always #2 clk = ~clk;

  nibble_run_expander dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_byte(in_byte), .out_valid(out_valid), .out_ready(out_ready),
    .out_bit(out_bit), .err(err)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic push_code(input logic [3:0] v);
    if (v <= 4'd13) begin
      exp_q.push_back(1'b0);
      for (int i = 0; i < v; i++) exp_q.push_back(1'b1);
    end else if (v == 4'd14) begin
      for (int i = 0; i < 14; i++) exp_q.push_back(1'b1);
    end
  endtask

  task automatic send(input logic [7:0] b);
    bit r;
    push_code(b[7:4]);
    push_code(b[3:0]);
    @(negedge clk);
    in_valid = 1'b1;
    in_byte  = b;
    forever begin
      #1 r = in_ready;
      @(negedge clk);
      if (r) break;
    end
    in_valid = 1'b0;
    #1 check(in_ready == 1'b0, "R6 in_ready low while expanding", int'(in_ready), 0);
  endtask

  task automatic drain();
    int t = 0;
    while (exp_q.size() != 0 && t < 2000) begin
      @(negedge clk);
      t++;
    end
    repeat (4) @(negedge clk);
    check(exp_q.size() == 0, "R2 all expected bits delivered", exp_q.size(), 0);
  endtask

  // back-pressure pattern
  always @(negedge clk) begin
    lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    out_ready <= stall_en ? lfsr[0] : 1'b1;
  end

  // monitor / scoreboard
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (!rst) begin
        if (prev_stall) begin
          check(out_valid === 1'b1 && out_bit === prev_bit, "R7 hold under stall",
                int'(out_bit), int'(prev_bit));
        end
        if (out_valid && out_ready) begin
          if (exp_q.size() == 0) begin
            check(1'b0, "R5 unexpected bit (R2/R3/R4 stream)", int'(out_bit), -1);
          end else begin
            bit e;
            e = exp_q.pop_front();
            check(out_bit === e, "R2/R3/R4 stream bit", int'(out_bit), int'(e));
          end
        end
        prev_stall = out_valid && !out_ready;
        prev_bit   = out_bit;
      end else begin
        prev_stall = 1'b0;
      end
    end
  end

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        check(in_ready === 1'b1, "R1 in_ready after reset", int'(in_ready), 1);
        check(out_valid === 1'b0, "R1 out_valid after reset", int'(out_valid), 0);
        check(err === 1'b0, "R1 err after reset", int'(err), 0);
        // R2 short codes, R4 nibble order
        send(8'h00); send(8'h0D); send(8'hD0); send(8'h12); send(8'h5A);
        // R3 long runs chained
        send(8'hE3); send(8'hEE); send(8'h0E); send(8'hE0);
        drain();
        check(err === 1'b0, "R5 no error on valid codes", int'(err), 0);
        // R7 with random back-pressure
        stall_en = 1'b1;
        for (int i = 0; i < 40; i++) send(8'(i * 37 + 11) & 8'hEE);
        send(8'hDE); send(8'h0D); send(8'hE0);
        drain();
        // R5 reserved code
        send(8'hF3);
        drain();
        check(err === 1'b1, "R5 err set by code 15", int'(err), 1);
        send(8'h4F); send(8'hFF); send(8'h21);
        drain();
        check(err === 1'b1, "R5 err sticky", int'(err), 1);
        stall_en = 1'b0;
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        check(err === 1'b0, "R1 err cleared by reset", int'(err), 0);
        check(in_ready === 1'b1, "R1 in_ready after second reset", int'(in_ready), 1);
        send(8'h3E);
        drain();
      end
      begin
        repeat (100000) @(posedge clk);
        check(1'b0, "watchdog expired", 0, 1);
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule